// File: doc/BRIEF.md
# Banked Memory Conflict Resolver

This block sits in front of a 32-bank scratchpad and turns one request issued for a whole group of lanes into a series of conflict-free wavefronts. A request carries, for each of 32 lanes, an active bit, a predicate bit and a byte offset. Lanes that are both active and predicated on take part. Their offsets are decoded into a bank and a row. Each wavefront then gives every bank exactly one row to read and says which lanes that read serves. The crossbar that follows receives, for each bank, the mask of lanes it feeds.

Wavefronts are built by scanning lanes from lowest to highest. The first pending lane that reaches a bank fixes that bank's row. Any later pending lane that reaches the same bank and the same row rides along in the same wavefront (broadcast), whatever its byte position inside the word. A lane that needs another row of an already claimed bank waits for a later wavefront. Served lanes leave the pending set, and the block emits one registered wavefront per clock under a valid/ready handshake until nothing is left. It then pulses done. If a participating lane points past the configured memory size, the request raises an error and produces no wavefronts.

Top module: `smem_wave_resolver`

## Requirements
- R1: After reset, req_ready is 1 and wf_valid, done and oob_err are 0.
- R2: Only lanes with both req_active and req_pred set take part. Any other lane never appears in wf_lanes, whatever its offset.
- R3: Each lane's offset decodes as follows: bits [1:0] are the byte within the word and play no part in grouping, bits [6:2] are the bank, and bits [13:7] are the row.
- R4: In each wavefront, the row of a bank is taken from the lowest-numbered pending lane that targets that bank. wf_lanes is exactly the set of pending lanes whose bank and row match the row fixed for their bank.
- R5: Pending lanes that target the same bank and row share one wavefront, even when their byte bits differ.
- R6: Pending lanes that target the same bank at different rows go to successive wavefronts. For example, 32 lanes on one bank with 32 distinct rows give 32 wavefronts of one lane each, in lane order.
- R7: In each wavefront, wf_bank_en[b] is 1 exactly when some served lane targets bank b. Slice b of wf_rows holds that bank's row, or 0 when the bank is idle. Slice b of wf_bank_lanes holds the served lanes that target bank b.
- R8: The wavefronts of one request are disjoint, and together they equal the participating lane set. wf_last is 1 on the final wavefront only.
- R9: req_ready is 0 from the accept edge until the last wavefront has been taken. done is high for exactly one cycle, in the cycle after the final wavefront handshake, and req_ready is 1 again in that cycle.
- R10: A request with no participating lane raises done in the cycle after it is accepted, produces no wavefront, and keeps oob_err at 0.
- R11: If any participating lane has an offset of MEM_BYTES (12288) or more, oob_err and done are both high in the cycle after acceptance, and no wavefront is produced. Out-of-range offsets on non-participating lanes are ignored.
- R12: While wf_valid is 1 and wf_ready is 0, every wavefront output holds its value. With wf_ready held at 1, wavefronts come out on consecutive cycles, and the first one appears two cycles after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Resolver idle and able to take a request |
| req_active | input | 32 | Per-lane active bits |
| req_pred | input | 32 | Per-lane predicate bits |
| req_offs | input | 32x14 | Per-lane byte offsets, lane i in slice i |
| wf_valid | output | 1 | Wavefront present |
| wf_ready | input | 1 | Downstream takes the wavefront |
| wf_lanes | output | 32 | Lanes served by this wavefront |
| wf_bank_en | output | 32 | Banks that read in this wavefront |
| wf_rows | output | 32x7 | Row selected for each bank |
| wf_bank_lanes | output | 32x32 | Per-bank mask of lanes fed by that bank |
| wf_last | output | 1 | Final wavefront of the request |
| done | output | 1 | One-cycle pulse when a request completes |
| oob_err | output | 1 | One-cycle pulse with done for an out-of-range request |

## Verification
The properties assume that wf_ready does not depend on any output in the same cycle. They also assume that a request held on the inputs while req_ready is 0 has no effect. The bench drives every input at the falling edge, raises req_valid only when the resolver is idle, and drops it right after the accepting edge. The expected wavefront sequences come from a lane-by-lane model in the bench. The patterns cover spread, broadcast, fully serialized, strided, masked, empty and out-of-range requests, with both a steady ready and a stalling one.

// File: rtl/smem_pkg.sv
package smem_pkg;
    localparam int DEF_LANES     = 32;
    localparam int DEF_BANKS     = 32;
    localparam int DEF_OFF_W     = 14;
    localparam int DEF_MEM_BYTES = 12288;
    localparam int BYTE_W        = 2;   // byte select bits inside a 32-bit word
endpackage

// File: rtl/smem_lane_split.sv
module smem_lane_split #(
    parameter int OFF_W     = smem_pkg::DEF_OFF_W,
    parameter int BANK_W    = 5,
    parameter int ROW_W     = OFF_W - BANK_W - smem_pkg::BYTE_W,
    parameter int MEM_BYTES = smem_pkg::DEF_MEM_BYTES
) (
    input  logic [OFF_W-1:0]  off,
    output logic [BANK_W-1:0] bank,
    output logic [ROW_W-1:0]  row,
    output logic              oob
);
    localparam logic [OFF_W:0] LIMIT = (OFF_W+1)'(MEM_BYTES);

    assign bank = off[smem_pkg::BYTE_W +: BANK_W];
    assign row  = off[OFF_W-1 -: ROW_W];
    assign oob  = {1'b0, off} >= LIMIT;
endmodule

// File: rtl/smem_wave_pick.sv
module smem_wave_pick #(
    parameter int LANES  = smem_pkg::DEF_LANES,
    parameter int BANKS  = smem_pkg::DEF_BANKS,
    parameter int BANK_W = $clog2(BANKS),
    parameter int ROW_W  = 7
) (
    input  logic [LANES-1:0]                  pending,
    input  logic [LANES-1:0][BANK_W-1:0]      lane_bank,
    input  logic [LANES-1:0][ROW_W-1:0]       lane_row,
    output logic [LANES-1:0]                  served,
    output logic [BANKS-1:0]                  bank_en,
    output logic [BANKS-1:0][ROW_W-1:0]       bank_row,
    output logic [BANKS-1:0][LANES-1:0]       bank_lanes
);
    // Per bank: the lowest pending lane that targets it fixes the row.
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic             en_b;
        logic [ROW_W-1:0] row_b;
        always_comb begin
            en_b  = 1'b0;
            row_b = '0;
            for (int i = LANES - 1; i >= 0; i--) begin
                if (pending[i] && (lane_bank[i] == BANK_W'(b))) begin
                    en_b  = 1'b1;
                    row_b = lane_row[i];
                end
            end
        end
        assign bank_en[b]  = en_b;
        assign bank_row[b] = row_b;
    end

    // Per lane: served when its row matches the one chosen for its bank.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign served[i] = pending[i] && (bank_row[lane_bank[i]] == lane_row[i]);
    end

    for (genvar b = 0; b < BANKS; b++) begin : g_mask
        for (genvar i = 0; i < LANES; i++) begin : g_bit
            assign bank_lanes[b][i] = served[i] && (lane_bank[i] == BANK_W'(b));
        end
    end
endmodule

// File: rtl/smem_wave_resolver.sv
module smem_wave_resolver #(
    parameter int LANES     = smem_pkg::DEF_LANES,
    parameter int BANKS     = smem_pkg::DEF_BANKS,
    parameter int OFF_W     = smem_pkg::DEF_OFF_W,
    parameter int MEM_BYTES = smem_pkg::DEF_MEM_BYTES,
    parameter int BANK_W    = $clog2(BANKS),
    parameter int ROW_W     = OFF_W - BANK_W - smem_pkg::BYTE_W
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             req_valid,
    output logic                             req_ready,
    input  logic [LANES-1:0]                 req_active,
    input  logic [LANES-1:0]                 req_pred,
    input  logic [LANES-1:0][OFF_W-1:0]      req_offs,
    output logic                             wf_valid,
    input  logic                             wf_ready,
    output logic [LANES-1:0]                 wf_lanes,
    output logic [BANKS-1:0]                 wf_bank_en,
    output logic [BANKS-1:0][ROW_W-1:0]      wf_rows,
    output logic [BANKS-1:0][LANES-1:0]      wf_bank_lanes,
    output logic                             wf_last,
    output logic                             done,
    output logic                             oob_err
);
    typedef struct packed {
        logic                           busy;
        logic [LANES-1:0]               pend;
        logic [LANES-1:0][BANK_W-1:0]   bank;
        logic [LANES-1:0][ROW_W-1:0]    row;
        logic                           ov;
        logic [LANES-1:0]               olanes;
        logic [BANKS-1:0]               oen;
        logic [BANKS-1:0][ROW_W-1:0]    orow;
        logic [BANKS-1:0][LANES-1:0]    obl;
        logic                           olast;
        logic                           done;
        logic                           err;
    } state_t;

    state_t st_d, st_q;

    // Lane decode on the incoming request
    logic [LANES-1:0][BANK_W-1:0] in_bank;
    logic [LANES-1:0][ROW_W-1:0]  in_row;
    logic [LANES-1:0]             in_oob;

    for (genvar i = 0; i < LANES; i++) begin : g_split
        smem_lane_split #(
            .OFF_W(OFF_W), .BANK_W(BANK_W), .ROW_W(ROW_W), .MEM_BYTES(MEM_BYTES)
        ) u_split (
            .off (req_offs[i]),
            .bank(in_bank[i]),
            .row (in_row[i]),
            .oob (in_oob[i])
        );
    end

    // Wavefront selection on the stored request
    logic [LANES-1:0]             pk_served;
    logic [BANKS-1:0]             pk_en;
    logic [BANKS-1:0][ROW_W-1:0]  pk_row;
    logic [BANKS-1:0][LANES-1:0]  pk_bl;

    smem_wave_pick #(
        .LANES(LANES), .BANKS(BANKS), .BANK_W(BANK_W), .ROW_W(ROW_W)
    ) u_pick (
        .pending   (st_q.pend),
        .lane_bank (st_q.bank),
        .lane_row  (st_q.row),
        .served    (pk_served),
        .bank_en   (pk_en),
        .bank_row  (pk_row),
        .bank_lanes(pk_bl)
    );

    logic [LANES-1:0] take_mask;
    logic             any_bad;
    logic [LANES-1:0] left_after;

    always_comb begin
        st_d       = st_q;
        st_d.done  = 1'b0;
        st_d.err   = 1'b0;
        take_mask  = req_active & req_pred;
        any_bad    = |(take_mask & in_oob);
        left_after = st_q.pend & ~pk_served;

        if (req_valid && !st_q.busy) begin
            if ((take_mask == '0) || any_bad) begin
                st_d.done = 1'b1;
                st_d.err  = any_bad;
            end else begin
                st_d.busy = 1'b1;
                st_d.pend = take_mask;
                st_d.bank = in_bank;
                st_d.row  = in_row;
            end
        end

        if (st_q.busy) begin
            if (st_q.ov && wf_ready) begin
                st_d.ov = 1'b0;
                if (st_q.olast) begin
                    st_d.busy = 1'b0;
                    st_d.done = 1'b1;
                end
            end
            if ((!st_q.ov || wf_ready) && (st_q.pend != '0)) begin
                st_d.ov     = 1'b1;
                st_d.olanes = pk_served;
                st_d.oen    = pk_en;
                st_d.orow   = pk_row;
                st_d.obl    = pk_bl;
                st_d.olast  = (left_after == '0);
                st_d.pend   = left_after;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready     = !st_q.busy;
    assign wf_valid      = st_q.ov;
    assign wf_lanes      = st_q.olanes;
    assign wf_bank_en    = st_q.oen;
    assign wf_rows       = st_q.orow;
    assign wf_bank_lanes = st_q.obl;
    assign wf_last       = st_q.olast;
    assign done          = st_q.done;
    assign oob_err       = st_q.err;
endmodule

// File: rtl/smem_wave_resolver_chk.sv
module smem_wave_resolver_chk #(
    parameter int LANES = 32,
    parameter int BANKS = 32,
    parameter int ROW_W = 7
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        req_ready,
    input logic                        wf_valid,
    input logic                        wf_ready,
    input logic [LANES-1:0]            wf_lanes,
    input logic [BANKS-1:0]            wf_bank_en,
    input logic [BANKS-1:0][ROW_W-1:0] wf_rows,
    input logic                        wf_last,
    input logic                        done,
    input logic                        oob_err
);
    // R12
    wf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wf_valid && !wf_ready) |=> (wf_valid && $stable(wf_lanes) && $stable(wf_rows)
                                     && $stable(wf_bank_en) && $stable(wf_last)));

    // R9
    busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wf_valid |-> !req_ready);

    // R9
    last_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wf_valid && wf_ready && wf_last) |=> (done && req_ready));

    // R11
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oob_err |-> (done && !wf_valid));

    // R7
    lanes_cover_banks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wf_valid |-> ((wf_lanes != '0) && ($countones(wf_lanes) >= $countones(wf_bank_en))));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done || !$past(wf_valid));
endmodule

bind smem_wave_resolver smem_wave_resolver_chk #(
    .LANES(LANES), .BANKS(BANKS), .ROW_W(ROW_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .wf_valid  (wf_valid),
    .wf_ready  (wf_ready),
    .wf_lanes  (wf_lanes),
    .wf_bank_en(wf_bank_en),
    .wf_rows   (wf_rows),
    .wf_last   (wf_last),
    .done      (done),
    .oob_err   (oob_err)
);

// File: tb/smem_wave_resolver_tb.sv
module smem_wave_resolver_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic                    req_valid = 1'b0;
    logic                    req_ready;
    logic [31:0]             req_active = '0;
    logic [31:0]             req_pred = '0;
    logic [31:0][13:0]       req_offs = '0;
    logic                    wf_valid;
    logic                    wf_ready = 1'b1;
    logic [31:0]             wf_lanes;
    logic [31:0]             wf_bank_en;
    logic [31:0][6:0]        wf_rows;
    logic [31:0][31:0]       wf_bank_lanes;
    logic                    wf_last;
    logic                    done;
    logic                    oob_err;

    smem_wave_resolver u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_active(req_active), .req_pred(req_pred), .req_offs(req_offs),
        .wf_valid(wf_valid), .wf_ready(wf_ready),
        .wf_lanes(wf_lanes), .wf_bank_en(wf_bank_en), .wf_rows(wf_rows),
        .wf_bank_lanes(wf_bank_lanes), .wf_last(wf_last),
        .done(done), .oob_err(oob_err)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [31:0]       exp_lanes [0:32];
    logic [31:0]       exp_en    [0:32];
    logic [31:0][6:0]  exp_rows  [0:32];
    logic [31:0][31:0] exp_bl    [0:32];
    int                exp_n;
    bit                exp_err;

    task automatic chk(input bit ok, input string tag, input logic [1023:0] act, input logic [1023:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Model from the requirements: R2 lane set, R3 decode, R4-R7 grouping
    task automatic build_exp();
        logic [31:0] pend;
        logic [31:0] en;
        logic [31:0][6:0] rw;
        logic [31:0] sv;
        logic [31:0][31:0] bl;
        int b;
        logic [6:0] r;
        pend = req_active & req_pred;
        exp_err = 1'b0;
        for (int i = 0; i < 32; i++)
            if (pend[i] && (req_offs[i] >= 14'd12288)) exp_err = 1'b1;
        exp_n = 0;
        if (exp_err) pend = '0;
        while (pend != '0) begin
            en = '0; rw = '0; sv = '0; bl = '0;
            for (int i = 0; i < 32; i++) begin
                if (pend[i]) begin
                    b = int'(req_offs[i][6:2]);
                    r = req_offs[i][13:7];
                    if (!en[b]) begin
                        en[b] = 1'b1;
                        rw[b] = r;
                    end
                    if (rw[b] == r) begin
                        sv[i] = 1'b1;
                        bl[b][i] = 1'b1;
                    end
                end
            end
            exp_lanes[exp_n] = sv;
            exp_en[exp_n]    = en;
            exp_rows[exp_n]  = rw;
            exp_bl[exp_n]    = bl;
            exp_n++;
            pend = pend & ~sv;
        end
    endtask

    // One request: drive, collect wavefronts, compare
    task automatic run_req(input string tag, input bit stall);
        int k;
        int cyc;
        bit prev_last_hs;
        bit prev_stall;
        bit seen_done;
        bit hs;
        logic [31:0] p_lanes;
        logic [31:0][6:0] p_rows;
        build_exp();
        @(negedge clk);
        chk(req_ready == 1'b1, {tag, " R9 ready when idle"}, 1024'(req_ready), 1024'(1));
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        k = 0; cyc = 0; prev_last_hs = 0; prev_stall = 0; seen_done = 0;
        p_lanes = '0; p_rows = '0;
        while (!seen_done && cyc < 300) begin
            wf_ready = stall ? ((cyc % 3) != 1) : 1'b1;
            if (prev_stall) begin
                chk(wf_valid && (wf_lanes == p_lanes) && (wf_rows == p_rows),
                    {tag, " R12 hold under stall"}, 1024'({wf_lanes, wf_rows}), 1024'({p_lanes, p_rows}));
            end
            if (done) begin
                seen_done = 1'b1;
                chk((exp_n == 0) ? (cyc == 0) : prev_last_hs,
                    {tag, (exp_n == 0) ? " R10 done timing" : " R9 done after last"},
                    1024'(cyc), 1024'(exp_n));
                chk(k == exp_n, {tag, " R6 wavefront count"}, 1024'(k), 1024'(exp_n));
                chk(oob_err == exp_err, {tag, " R11 error flag"}, 1024'(oob_err), 1024'(exp_err));
                chk(req_ready == 1'b1, {tag, " R9 ready at done"}, 1024'(req_ready), 1024'(1));
                if (!stall && exp_n > 0)
                    chk(cyc == exp_n + 1, {tag, " R12 back-to-back"}, 1024'(cyc), 1024'(exp_n + 1));
            end else begin
                hs = wf_valid && wf_ready;
                prev_stall = wf_valid && !wf_ready;
                p_lanes = wf_lanes;
                p_rows = wf_rows;
                prev_last_hs = hs && wf_last;
                if (wf_valid) begin
                    chk(req_ready == 1'b0, {tag, " R9 busy"}, 1024'(req_ready), 1024'(0));
                end
                if (hs) begin
                    if (k >= exp_n) begin
                        chk(1'b0, {tag, " R8 extra wavefront"}, 1024'(k), 1024'(exp_n));
                    end else begin
                        chk(wf_lanes == exp_lanes[k], {tag, " R4 served lanes"},
                            1024'(wf_lanes), 1024'(exp_lanes[k]));
                        chk((wf_bank_en == exp_en[k]) && (wf_rows == exp_rows[k]),
                            {tag, " R7 bank enables and rows"},
                            1024'({wf_bank_en, wf_rows}), 1024'({exp_en[k], exp_rows[k]}));
                        chk(wf_bank_lanes == exp_bl[k], {tag, " R7 bank lane masks"},
                            1024'(wf_bank_lanes), 1024'(exp_bl[k]));
                        chk(wf_last == (k == exp_n - 1), {tag, " R8 last flag"},
                            1024'(wf_last), 1024'(k == exp_n - 1));
                    end
                    k++;
                end
            end
            cyc++;
            @(negedge clk);
        end
        if (!seen_done) chk(1'b0, {tag, " R9 no done"}, 1024'(cyc), 1024'(exp_n));
        chk(done == 1'b0, {tag, " R9 done is a pulse"}, 1024'(done), 1024'(0));
        wf_ready = 1'b1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(req_ready && !wf_valid && !done && !oob_err, "R1 reset state",
            1024'({req_ready, wf_valid, done, oob_err}), 1024'(4'b1000));
    endtask

    task automatic t_spread();
        req_active = '1; req_pred = '1;
        for (int i = 0; i < 32; i++) req_offs[i] = 14'(i * 4 + 128 * 5);
        run_req("R4 spread", 1'b0);
    endtask

    task automatic t_broadcast();
        req_active = '1; req_pred = '1;
        for (int i = 0; i < 32; i++) req_offs[i] = 14'(12 + (i % 4) + 128 * 9);
        run_req("R5 broadcast", 1'b0);
    endtask

    task automatic t_decode();
        req_active = '1; req_pred = '1;
        for (int i = 0; i < 32; i++) req_offs[i] = 14'(i * 4 + (i % 4) + 128 * (i % 3));
        run_req("R3 decode", 1'b0);
    endtask

    task automatic t_serial();
        req_active = '1; req_pred = '1;
        for (int i = 0; i < 32; i++) req_offs[i] = 14'(i * 128);
        run_req("R6 serial", 1'b0);
    endtask

    task automatic t_wide();
        req_active = '1; req_pred = '1;
        for (int i = 0; i < 32; i++) req_offs[i] = 14'(i * 8);
        run_req("R6 wide stride", 1'b0);
    endtask

    task automatic t_masked();
        req_active = 32'hF0F3_5A5F; req_pred = 32'h3FFC_FF3C;
        for (int i = 0; i < 32; i++) req_offs[i] = 14'(((i % 4) * 128) + ((i / 4) % 3) * 4 + (i % 2));
        run_req("R2 masked", 1'b0);
    endtask

    task automatic t_empty();
        req_active = 32'h0000_FFFF; req_pred = 32'hFFFF_0000;
        for (int i = 0; i < 32; i++) req_offs[i] = 14'(i);
        run_req("R10 empty", 1'b0);
    endtask

    task automatic t_oob();
        req_active = '1; req_pred = '1;
        for (int i = 0; i < 32; i++) req_offs[i] = 14'(i * 4);
        req_offs[17] = 14'd12288;
        run_req("R11 out of range", 1'b0);
    endtask

    task automatic t_oob_ignored();
        req_active = 32'hFFFF_FFFE; req_pred = '1;
        for (int i = 0; i < 32; i++) req_offs[i] = 14'(i * 4 + 256);
        req_offs[0] = 14'd16000;
        run_req("R11 ignored lane", 1'b0);
    endtask

    task automatic t_stall();
        req_active = '1; req_pred = 32'h00FF_FF00;
        for (int i = 0; i < 32; i++) req_offs[i] = 14'((i % 2) * 4 + (i % 5) * 128);
        run_req("R12 stall", 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_spread();
        t_broadcast();
        t_decode();
        t_serial();
        t_wide();
        t_masked();
        t_empty();
        t_oob();
        t_oob_ignored();
        t_stall();
        t_serial();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        #(8 * 100000);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule